// File: doc/BRIEF.md
# Diminished-One Residue Multiply-Accumulate

This block is a clocked multiply-accumulate unit for residue arithmetic modulo 2^W+1. Its residues span 0 to 2^W. Every value, on the inputs and in the accumulator, uses a W-bit diminished code: a nonzero residue X is carried as X−1. A separate flag marks zero, which has no code of its own in the W-bit field. On each cycle where the valid input is high, the unit forms the product of its two operands modulo 2^W+1. It adds that product to the accumulator register, also modulo 2^W+1.

The multiplier first restores the true operand values. It builds one shifted row for each multiplier bit and compresses the rows with a carry-save tree of 3:2 counters until two rows remain. One carry-propagate add and a fold of the high half against the low half then give the residue. The accumulate adder works directly on diminished codes. It uses a Kogge-Stone prefix network whose group carry-out, inverted, is fed back in as the end-around carry-in. A zero operand on either side of the adder passes the other operand through unchanged.

Top module: `dm1_mac`

## Requirements
- R1: A nonzero residue X is presented and reported as the W-bit code X−1 with its zero flag low. Zero is reported with the flag high and a code field of all zeros.
- R2: While rst_n is low at a rising clock edge, the accumulator becomes zero (flag high, code 0).
- R3: When clr is high at a rising edge with rst_n high, the accumulator becomes zero, whatever in_vld holds.
- R4: With in_vld low and clr low, the accumulator keeps its value.
- R5: With in_vld high and clr low, the accumulator takes (acc + A·B) mod (2^W+1) at the edge. A and B are the residues encoded on the operand ports.
- R6: If either operand's zero flag is high, the product is zero and a valid cycle leaves the accumulator unchanged. The code bits of an operand whose flag is high have no effect.
- R7: An accumulation whose true sum equals 2^W+1 wraps to zero, with the zero flag high.
- R8: The largest operands, 2^W times 2^W (code all ones on both inputs), give a product of residue 1 (code 0, flag low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous accumulator clear |
| in_vld | input | 1 | Accumulate this cycle |
| a_code | input | W | Operand A, diminished code |
| a_zero | input | 1 | Operand A is zero |
| b_code | input | W | Operand B, diminished code |
| b_zero | input | 1 | Operand B is zero |
| acc_code | output | W | Accumulator, diminished code |
| acc_zero | output | 1 | Accumulator is zero |

## Verification
The hardest case to reach from the ports is the adder's zero outcome. It happens only when the two diminished codes sum to exactly all ones, so the accumulator and the product must be exact additive inverses modulo 2^W+1. Random operands seldom produce this. A directed sequence therefore first sets the accumulator to 2^W (16 times 16 at W=8) and then adds 1 times 1. The largest-operand product, whose full value 2^2W fills the top of the partial-product array, is driven directly in the same way. A long random run mixes zero operands that carry garbage code bits, idle cycles and clears.

// File: rtl/dm1_pkg.sv
// Shared helpers for the diminished-one residue blocks.
// Assumes row counts are small positive integers known at elaboration.
package dm1_pkg;

    // Number of rows left after lv layers of 3:2 compression.
    function automatic int rows_after(input int rows, input int lv);
        int n;
        n = rows;
        for (int i = 0; i < lv; i++) n = 2 * (n / 3) + n % 3;
        return n;
    endfunction

    // Layers of 3:2 compression needed to bring rows down to two.
    function automatic int tree_depth(input int rows);
        int n;
        int l;
        n = rows;
        l = 0;
        while (n > 2) begin
            n = 2 * (n / 3) + n % 3;
            l++;
        end
        return l;
    endfunction

endpackage

// File: rtl/dm1_adder.sv
// Diminished-one adder modulo 2^W+1.
// Computes S* = A* + B* + 1 (mod 2^W+1) on W-bit codes. A Kogge-Stone
// prefix tree gives the group carry-out. That carry-out is inverted and
// fed back as carry-in, with one extra combine level. A zero flag on
// one input passes the other input straight through. Assumes a code is
// 0 whenever its flag is set.
module dm1_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_code,
    input  logic         x_zero,
    input  logic [W-1:0] y_code,
    input  logic         y_zero,
    output logic [W-1:0] s_code,
    output logic         s_zero
);
    localparam int LG = (W > 1) ? $clog2(W) : 0;

    logic [W-1:0] gen [LG+1];
    logic [W-1:0] prp [LG+1];
    logic [W-1:0] carry;
    logic [W-1:0] raw_sum;
    logic         cin;
    logic         raw_zero;

    assign gen[0] = x_code & y_code;
    assign prp[0] = x_code ^ y_code;

    // Prefix levels: span doubles on each level.
    for (genvar k = 0; k < LG; k++) begin : g_lvl
        localparam int D = 1 << k;
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i >= D) begin : g_cmb
                assign gen[k+1][i] = gen[k][i] | (prp[k][i] & gen[k][i-D]);
                assign prp[k+1][i] = prp[k][i] & prp[k][i-D];
            end else begin : g_cpy
                assign gen[k+1][i] = gen[k][i];
                assign prp[k+1][i] = prp[k][i];
            end
        end
    end

    // Inverted end-around carry, combined into each bit position.
    assign cin      = ~gen[LG][W-1];
    assign carry[0] = cin;
    for (genvar i = 1; i < W; i++) begin : g_car
        assign carry[i] = gen[LG][i-1] | (prp[LG][i-1] & cin);
    end
    assign raw_sum  = prp[0] ^ carry;
    assign raw_zero = cin & prp[LG][W-1];

    // Select pass-through or the prefix sum.
    always_comb begin
        if (x_zero) begin
            s_code = y_code;
            s_zero = y_zero;
        end else if (y_zero) begin
            s_code = x_code;
            s_zero = 1'b0;
        end else begin
            s_code = raw_sum;
            s_zero = raw_zero;
        end
    end
endmodule

// File: rtl/dm1_mult.sv
// Diminished-one multiplier modulo 2^W+1.
// Restores true operands (code+1) and forms W+1 shifted partial rows.
// A tree of 3:2 counters reduces the rows to two. One add gives the
// full product P. The fold P mod 2^W+1 = L - H uses the low half L and
// the high half H, with a single correction by +M. Either zero flag
// forces a zero product.
module dm1_mult #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_code,
    input  logic         a_zero,
    input  logic [W-1:0] b_code,
    input  logic         b_zero,
    output logic [W-1:0] p_code,
    output logic         p_zero
);
    import dm1_pkg::*;

    localparam int AW = W + 1;
    localparam int PW = 2 * W + 2;
    localparam int R  = W + 1;
    localparam int LV = tree_depth(R);
    localparam logic [W+1:0] MOD = (W + 2)'((1 << W) + 1);

    logic [AW-1:0] a_true;
    logic [AW-1:0] b_true;
    logic [PW-1:0] pp [R];
    logic [PW-1:0] fin0;
    logic [PW-1:0] fin1;
    logic [PW-1:0] full;
    logic [W+1:0]  diff;
    logic [W+1:0]  res;

    assign a_true = AW'(a_code) + AW'(1);
    assign b_true = AW'(b_code) + AW'(1);

    // One row per multiplier bit.
    for (genvar i = 0; i < R; i++) begin : g_pp
        assign pp[i] = b_true[i] ? (PW'(a_true) << i) : '0;
    end

    // Compression layers: each group of three rows becomes two.
    for (genvar l = 0; l < LV; l++) begin : lvl
        localparam int NIN  = rows_after(R, l);
        localparam int NG   = NIN / 3;
        localparam int NR   = NIN % 3;
        localparam int NOUT = 2 * NG + NR;
        logic [PW-1:0] cur [NIN];
        logic [PW-1:0] nxt [NOUT];
        if (l == 0) begin : g_src0
            for (genvar j = 0; j < NIN; j++) begin : g_j
                assign cur[j] = pp[j];
            end
        end else begin : g_srcn
            for (genvar j = 0; j < NIN; j++) begin : g_j
                assign cur[j] = lvl[l-1].nxt[j];
            end
        end
        for (genvar g = 0; g < NG; g++) begin : g_csa
            assign nxt[2*g]   = cur[3*g] ^ cur[3*g+1] ^ cur[3*g+2];
            assign nxt[2*g+1] = ((cur[3*g] & cur[3*g+1]) | (cur[3*g] & cur[3*g+2])
                               | (cur[3*g+1] & cur[3*g+2])) << 1;
        end
        for (genvar k = 0; k < NR; k++) begin : g_pass
            assign nxt[2*NG+k] = cur[3*NG+k];
        end
    end

    if (LV == 0) begin : g_fin0
        assign fin0 = pp[0];
        assign fin1 = pp[1];
    end else begin : g_finn
        assign fin0 = lvl[LV-1].nxt[0];
        assign fin1 = lvl[LV-1].nxt[1];
    end

    assign full = fin0 + fin1;

    // Fold high half against low half, then correct a negative result.
    always_comb begin
        diff = {2'b00, full[W-1:0]} - full[PW-1:W];
        res  = diff[W+1] ? diff + MOD : diff;
    end

    assign p_zero = a_zero | b_zero | (res == '0);
    assign p_code = p_zero ? '0 : (res[W-1:0] - W'(1));
endmodule

// File: rtl/dm1_mac.sv
// Multiply-accumulate modulo 2^W+1 on diminished-one codes.
// Each valid cycle: acc <= acc + A*B (mod 2^W+1). A synchronous clear
// or the active-low reset sets the accumulator to zero. Assumes operand
// codes are don't-care whenever their zero flag is high.
module dm1_mac #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         in_vld,
    input  logic [W-1:0] a_code,
    input  logic         a_zero,
    input  logic [W-1:0] b_code,
    input  logic         b_zero,
    output logic [W-1:0] acc_code,
    output logic         acc_zero
);
    logic [W-1:0] prod_code;
    logic         prod_zero;
    logic [W-1:0] sum_code;
    logic         sum_zero;

    dm1_mult #(.W(W)) u_mult (
        .a_code (a_code),
        .a_zero (a_zero),
        .b_code (b_code),
        .b_zero (b_zero),
        .p_code (prod_code),
        .p_zero (prod_zero)
    );

    dm1_adder #(.W(W)) u_add (
        .x_code (prod_code),
        .x_zero (prod_zero),
        .y_code (acc_code),
        .y_zero (acc_zero),
        .s_code (sum_code),
        .s_zero (sum_zero)
    );

    // Accumulator register: reset/clear to zero, else load on valid.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_code <= '0;
            acc_zero <= 1'b1;
        end else if (in_vld) begin
            acc_code <= sum_code;
            acc_zero <= sum_zero;
        end
    end

    // R3
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_zero && acc_code == '0));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !in_vld) |=> ($stable(acc_code) && $stable(acc_zero)));

    // R6
    zero_op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && in_vld && (a_zero || b_zero)) |=> ($stable(acc_code) && $stable(acc_zero)));

    // R6
    zero_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_zero || b_zero) |-> (prod_zero && sum_code == acc_code && sum_zero == acc_zero));

    // R1
    zero_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_zero |-> (acc_code == '0));
endmodule

// File: tb/dm1_mac_bench.sv
module dm1_mac_bench;
    localparam int W      = 8;
    localparam int MODV   = (1 << W) + 1;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         in_vld = 1'b0;
    logic [W-1:0] a_code = '0;
    logic         a_zero = 1'b1;
    logic [W-1:0] b_code = '0;
    logic         b_zero = 1'b1;
    logic [W-1:0] acc_code;
    logic         acc_zero;

    int total = 0;
    int fails = 0;
    int model = 0;

    always #(PERIOD/2) clk = ~clk;

    dm1_mac #(.W(W)) u_dm1_mac (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld),
        .a_code(a_code), .a_zero(a_zero), .b_code(b_code), .b_zero(b_zero),
        .acc_code(acc_code), .acc_zero(acc_zero)
    );

    function automatic int exp_code(input int v);
        return (v == 0) ? 0 : v - 1;
    endfunction

    task automatic check(input string req);
        total++;
        if (acc_zero !== (model == 0) || int'(acc_code) != exp_code(model)) begin
            fails++;
            $display("FAIL %s: got zero=%0b code=%0d, expected zero=%0b code=%0d",
                     req, acc_zero, acc_code, (model == 0), exp_code(model));
        end
    endtask

    // Drive one cycle right after an edge, update the model, check after the next edge.
    task automatic step(input bit v, input int a, input int b, input bit c, input string req);
        a_zero = (a == 0);
        b_zero = (b == 0);
        a_code = a_zero ? W'($urandom) : W'(a - 1);
        b_code = b_zero ? W'($urandom) : W'(b - 1);
        in_vld = v;
        clr    = c;
        @(posedge clk);
        #1;
        if (c) model = 0;
        else if (v) model = (model + a * b) % MODV;
        check(req);
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        total++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  %0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        @(posedge clk);
        @(posedge clk);
        #1;
        model = 0;
        check("R2 reset state");
        rst_n = 1'b1;

        // R5 plain accumulation, then R4 hold
        step(1, 3, 5, 0, "R5");
        step(1, 10, 20, 0, "R5");
        step(0, 7, 7, 0, "R4");
        // R6 zero operand with garbage code bits
        step(1, 0, 99, 0, "R6");
        step(1, 123, 0, 0, "R6");
        // R2 reset mid-stream
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        model = 0;
        check("R2");
        rst_n = 1'b1;
        // R7 wrap to zero: 256 then +1
        step(1, 16, 16, 0, "R7 setup");
        step(1, 1, 1, 0, "R7");
        step(1, 1, 1, 0, "R1 after wrap");
        // R8 extreme operands
        step(0, 0, 0, 1, "R3");
        step(1, MODV - 1, MODV - 1, 0, "R8");
        // R3 clear has priority over valid
        step(1, 200, 150, 1, "R3");

        for (int i = 0; i < 3000; i++) begin
            int a;
            int b;
            bit v;
            bit c;
            a = ($urandom % 4 == 0) ? 0 : int'($urandom % MODV);
            b = ($urandom % 4 == 0) ? 0 : int'($urandom % MODV);
            if ($urandom % 8 == 0) a = MODV - 1;
            v = ($urandom % 5 != 0);
            c = ($urandom % 60 == 0);
            if (c) step(v, a, b, c, "R3");
            else if (!v) step(v, a, b, c, "R4");
            else if (a == 0 || b == 0) step(v, a, b, c, "R6");
            else step(v, a, b, c, "R5");
        end

        $display("  %0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule